// File: doc/BRIEF.md
# I2C Length-Query Slave Bridge

This block is an I2C slave that links an external bus master to two byte queues on the host side. One queue holds bytes the host has staged for the master to read. The other collects bytes the master writes, for the host to drain. Each queue holds 62 bytes. The host sees both queues through plain valid/ready ports.

The master may not move data until it has asked how much it can move. First it issues a general-call write that carries a one-byte query code. Then it reads one byte back from the slave's own 7-bit address. That byte is either the free room in the write queue or the fill level of the read queue. After this answer the matching kind of data transfer is granted. The master then moves at most the reported number of bytes.

SCL and SDA are sampled through a two-flop synchronizer on the system clock. START and STOP are recognised from SDA edges that occur while SCL is high. The slave drives SDA only low, through an output-enable.

Top module: `i2c_lenq_bridge`

## Requirements
- R1: A write to address 0x00 (general call, R/W bit 0) is acknowledged, and so is its first byte. A first byte of 0xA3 queues a room query and 0xA4 queues a fill query. Any later bytes in the same transaction are acknowledged and ignored.
- R2: After a 0xA3 query, the first byte read from the own address (R/W bit 1) is 62 minus the number of bytes waiting in the write queue. After this answer, data writes are granted and data reads are withdrawn.
- R3: After a 0xA4 query, the first byte read from the own address is the number of bytes in the read queue. Any further bytes in that same read transaction are 0xFF and consume nothing. After this answer, data reads are granted and data writes are withdrawn.
- R4: A general-call byte other than 0xA3 or 0xA4 is acknowledged. The answer that follows it is 0x00, and it withdraws both grants.
- R5: While reads are granted, each byte read from the own address is the oldest byte of the read queue, sent MSB first, and is removed from the queue. A read with no grant, or with an empty queue, returns 0xFF and removes nothing. After a master NACK, the slave releases SDA until the next START or STOP.
- R6: While writes are granted and the write queue has room, each byte written to the own address is acknowledged (SDA low on the ninth clock) and appended in arrival order. Without a write grant, the data byte is NACKed and not stored.
- R7: A written byte that finds the write queue holding 62 bytes is NACKed and discarded. The bytes already queued are unchanged.
- R8: An address byte that matches neither 0x00-with-write nor the own address is not acknowledged and has no effect.
- R9: The staging port `h2m_ready` is low exactly while the read queue holds 62 bytes. While it is low, an offered byte is not stored. `m2h_valid` is high whenever the write queue is non-empty, and `m2h_data` shows its oldest byte.
- R10: The slave changes its SDA drive only while the synchronized SCL is low. It releases SDA in the cycle after a STOP.
- R11: After reset, SDA is released, `m2h_valid` is low and `h2m_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| own_addr | input | 7 | Slave address of this device |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| h2m_data | input | 8 | Byte staged by the host for the master |
| h2m_valid | input | 1 | Staged byte is offered |
| h2m_ready | output | 1 | Read queue can accept a byte |
| m2h_data | output | 8 | Oldest byte written by the master |
| m2h_valid | output | 1 | Write queue holds a byte |
| m2h_ready | input | 1 | Host takes the shown byte |

## Verification
The slave's SDA response to a bus event appears three clock cycles after the SCL edge that causes it: two synchronizer stages, then the drive register. The bench model of the bus master therefore reads SDA in the middle of the SCL high phase, at least twelve cycles after the preceding falling edge. A queue push or pop shows on the host ports in the cycle after the clock edge that performs it. All host-side values are sampled on the falling clock edge, a whole bit period or more after the bus activity that produced them. Lengths and data bytes are predicted from queue models kept in the bench. Acknowledge bits are predicted from the grant that the last answered query established.

// File: rtl/lenq_pkg.sv
package lenq_pkg;
    // query codes carried by the general-call write
    localparam logic [7:0] CMD_ROOM_Q = 8'hA3;
    localparam logic [7:0] CMD_FILL_Q = 8'hA4;
    // filler returned when no data may be read
    localparam logic [7:0] FILLER     = 8'hFF;

    typedef enum logic [1:0] {Q_NONE, Q_ROOM, Q_FILL} query_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ACKO, ST_RX, ST_TX, ST_TXACK, ST_WAIT
    } phase_e;
endpackage

// File: rtl/lenq_bus_sampler.sv
// Synchronizes SCL/SDA with two flops each and derives SCL edges and
// START/STOP events. Assumes bus levels change far slower than clk.
module lenq_bus_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_sy, sda_sy;
    logic       scl_d, sda_d;

    // two-stage synchronizer plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sy <= 2'b11;
            sda_sy <= 2'b11;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[0], scl_i};
            sda_sy <= {sda_sy[0], sda_i};
            scl_d  <= scl_sy[1];
            sda_d  <= sda_sy[1];
        end
    end

    assign scl_q     = scl_sy[1];
    assign sda_q     = sda_sy[1];
    assign scl_rise  = scl_q & ~scl_d;
    assign scl_fall  = ~scl_q & scl_d;
    assign start_det = scl_q & scl_d & sda_d & ~sda_q;
    assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/lenq_fifo.sv
// Byte queue of arbitrary (non power-of-two) depth with first-word
// fall-through read. Push when full and pop when empty are ignored.
module lenq_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 62,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty,
    output logic [CW-1:0]    count
);
    localparam int PW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr, rptr;
    logic             do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = mem[rptr];

    // storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    // pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R9
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R7
    fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == $past(count)));
    // R5
    fifo_pop_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/lenq_engine.sv
// I2C slave byte engine: address match, general-call query decode,
// length answer, and data movement to/from the two queues.
// Assumes synchronized SCL/SDA and single-cycle edge/START/STOP pulses.
module lenq_engine
    import lenq_pkg::*;
#(
    parameter int DEPTH = 62,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [6:0]    own_addr,
    input  logic          scl_q,
    input  logic          sda_q,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [7:0]    tx_dout,
    input  logic          tx_empty,
    input  logic [CW-1:0] tx_count,
    input  logic          rx_full,
    input  logic [CW-1:0] rx_count,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [7:0]    rx_din,
    output logic          sda_oe
);
    phase_e     phase;
    query_e     qkind;
    logic [3:0] cnt;
    logic [7:0] sh;
    logic       is_gc, is_rd, gc_seen, len_due, len_txn;
    logic       rgrant, wgrant, mack;
    logic       load, serve_len;
    logic [7:0] nxt_byte, len_val;

    // answer byte for the pending query
    always_comb begin
        case (qkind)
            Q_ROOM:  len_val = 8'(DEPTH) - 8'(rx_count);
            Q_FILL:  len_val = 8'(tx_count);
            default: len_val = 8'h00;
        endcase
    end

    // choose the next byte to shift out and whether it consumes queue data
    always_comb begin
        load      = scl_fall && ((phase == ST_ACKO && is_rd) ||
                                 (phase == ST_TXACK && mack));
        serve_len = load && len_due && !len_txn;
        tx_pop    = load && !serve_len && !len_txn && rgrant && !tx_empty;
        if (serve_len)   nxt_byte = len_val;
        else if (tx_pop) nxt_byte = tx_dout;
        else             nxt_byte = FILLER;
    end

    assign rx_push = (phase == ST_RX) && scl_fall && (cnt == 4'd8) &&
                     !is_gc && wgrant && !rx_full;
    assign rx_din  = sh;

    // bus protocol sequencing and grant bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= ST_IDLE;
            qkind   <= Q_NONE;
            cnt     <= '0;
            sh      <= '0;
            is_gc   <= 1'b0;
            is_rd   <= 1'b0;
            gc_seen <= 1'b0;
            len_due <= 1'b0;
            len_txn <= 1'b0;
            rgrant  <= 1'b0;
            wgrant  <= 1'b0;
            mack    <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (start_det) begin
            phase   <= ST_ADDR;
            cnt     <= '0;
            sda_oe  <= 1'b0;
            len_txn <= 1'b0;
        end else if (stop_det) begin
            phase   <= ST_IDLE;
            sda_oe  <= 1'b0;
            len_txn <= 1'b0;
        end else begin
            case (phase)
                ST_ADDR: begin
                    if (scl_rise) begin
                        sh  <= {sh[6:0], sda_q};
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall && cnt == 4'd8) begin
                        if (sh == 8'h00) begin
                            is_gc   <= 1'b1;
                            is_rd   <= 1'b0;
                            gc_seen <= 1'b0;
                            sda_oe  <= 1'b1;
                            phase   <= ST_ACKO;
                        end else if (sh[7:1] == own_addr) begin
                            is_gc  <= 1'b0;
                            is_rd  <= sh[0];
                            sda_oe <= 1'b1;
                            phase  <= ST_ACKO;
                        end else begin
                            phase <= ST_WAIT;
                        end
                    end
                end
                ST_ACKO: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (is_rd) begin
                            sh     <= nxt_byte;
                            sda_oe <= ~nxt_byte[7];
                            phase  <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            phase  <= ST_RX;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        sh  <= {sh[6:0], sda_q};
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall && cnt == 4'd8) begin
                        if (is_gc) begin
                            sda_oe <= 1'b1;
                            phase  <= ST_ACKO;
                            if (!gc_seen) begin
                                gc_seen <= 1'b1;
                                len_due <= 1'b1;
                                rgrant  <= 1'b0;
                                wgrant  <= 1'b0;
                                qkind   <= (sh == CMD_ROOM_Q) ? Q_ROOM :
                                           (sh == CMD_FILL_Q) ? Q_FILL : Q_NONE;
                            end
                        end else if (rx_push) begin
                            sda_oe <= 1'b1;
                            phase  <= ST_ACKO;
                        end else begin
                            phase <= ST_WAIT;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (cnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            phase  <= ST_TXACK;
                        end else begin
                            sh     <= {sh[6:0], 1'b0};
                            sda_oe <= ~sh[6];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_q;
                    end else if (scl_fall) begin
                        if (mack) begin
                            cnt    <= '0;
                            sh     <= nxt_byte;
                            sda_oe <= ~nxt_byte[7];
                            phase  <= ST_TX;
                        end else begin
                            phase <= ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
            if (serve_len) begin
                len_due <= 1'b0;
                len_txn <= 1'b1;
                rgrant  <= (qkind == Q_FILL);
                wgrant  <= (qkind == Q_ROOM);
            end
        end
    end

    // R10
    sda_move_lowscl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_q);
    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
    // R2
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serve_len |-> (len_val <= 8'(DEPTH)));
    // R6
    push_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> sda_oe);
endmodule

// File: rtl/i2c_lenq_bridge.sv
// Top: I2C slave bridge whose data transfers are gated by a general-call
// length query. Holds one queue toward the bus master and one from it.
// Assumes scl_i/sda_i are the wired-AND bus levels, including own drive.
module i2c_lenq_bridge #(
    parameter int DEPTH = 62
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] own_addr,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [7:0] h2m_data,
    input  logic       h2m_valid,
    output logic       h2m_ready,
    output logic [7:0] m2h_data,
    output logic       m2h_valid,
    input  logic       m2h_ready
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic          tx_pop, tx_full, tx_empty, rx_push, rx_full, rx_empty;
    logic [7:0]    tx_dout, rx_din;
    logic [CW-1:0] tx_count, rx_count;

    lenq_bus_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    lenq_fifo #(.WIDTH(8), .DEPTH(DEPTH), .CW(CW)) u_toq (
        .clk(clk), .rst_n(rst_n), .push(h2m_valid & h2m_ready),
        .din(h2m_data), .pop(tx_pop), .dout(tx_dout), .full(tx_full),
        .empty(tx_empty), .count(tx_count)
    );

    lenq_fifo #(.WIDTH(8), .DEPTH(DEPTH), .CW(CW)) u_fromq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_din),
        .pop(m2h_ready & m2h_valid), .dout(m2h_data), .full(rx_full),
        .empty(rx_empty), .count(rx_count)
    );

    lenq_engine #(.DEPTH(DEPTH), .CW(CW)) u_eng (
        .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .scl_q(scl_q),
        .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .tx_dout(tx_dout),
        .tx_empty(tx_empty), .tx_count(tx_count), .rx_full(rx_full),
        .rx_count(rx_count), .tx_pop(tx_pop), .rx_push(rx_push),
        .rx_din(rx_din), .sda_oe(sda_oe)
    );

    assign h2m_ready = ~tx_full;
    assign m2h_valid = ~rx_empty;
endmodule

// File: tb/sim_i2c_lenq_bridge.sv
module sim_i2c_lenq_bridge;
    localparam int DEPTH = 62;
    localparam int HP    = 10;
    localparam logic [6:0] OWN = 7'h51;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       m_scl = 1'b1;
    logic       m_sda_low = 1'b0;
    logic [7:0] h2m_data = 8'h00;
    logic       h2m_valid = 1'b0;
    logic       m2h_ready = 1'b0;
    logic       sda_oe, h2m_ready, m2h_valid;
    logic [7:0] m2h_data;
    wire        sda_line = ~(m_sda_low | sda_oe);

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    byte unsigned txq[$];
    byte unsigned rxq[$];

    i2c_lenq_bridge #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .own_addr(OWN), .scl_i(m_scl),
        .sda_i(sda_line), .sda_oe(sda_oe), .h2m_data(h2m_data),
        .h2m_valid(h2m_valid), .h2m_ready(h2m_ready), .m2h_data(m2h_data),
        .m2h_valid(m2h_valid), .m2h_ready(m2h_ready)
    );

    function automatic int exp_room();
        return DEPTH - rxq.size();
    endfunction

    function automatic int exp_fill();
        return txq.size();
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda_low = 1'b1; tick(HP);
        m_scl = 1'b0;
    endtask

    task automatic i2c_stop();
        tick(2); m_sda_low = 1'b1; tick(HP);
        m_scl = 1'b1; tick(HP);
        m_sda_low = 1'b0; tick(HP);
    endtask

    task automatic wb(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            tick(2); m_sda_low = ~b[i]; tick(HP);
            m_scl = 1'b1; tick(HP);
            m_scl = 1'b0;
        end
        tick(2); m_sda_low = 1'b0; tick(HP);
        m_scl = 1'b1; tick(HP / 2);
        ack = ~sda_line; tick(HP / 2);
        m_scl = 1'b0;
    endtask

    task automatic rb(input logic give_ack, output logic [7:0] b);
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            tick(2 + HP);
            m_scl = 1'b1; tick(HP / 2);
            b = {b[6:0], sda_line}; tick(HP / 2);
            m_scl = 1'b0;
        end
        tick(2); m_sda_low = give_ack; tick(HP);
        m_scl = 1'b1; tick(HP);
        m_scl = 1'b0; tick(2);
        m_sda_low = 1'b0;
    endtask

    task automatic query(input logic [7:0] code, input string req);
        logic a;
        i2c_start();
        wb(8'h00, a); chk({req, " general-call address ack"}, a, 1);
        wb(code, a);  chk({req, " query code ack"}, a, 1);
        i2c_stop();
    endtask

    task automatic read_len(input int exp, input string req);
        logic a;
        logic [7:0] b;
        i2c_start();
        wb({OWN, 1'b1}, a); chk({req, " read address ack"}, a, 1);
        rb(1'b0, b);        chk({req, " length byte"}, b, exp);
        i2c_stop();
    endtask

    task automatic host_push(input byte unsigned v);
        h2m_data = v; h2m_valid = 1'b1; tick(1);
        h2m_valid = 1'b0;
        txq.push_back(v);
    endtask

    task automatic host_pop(input string req);
        chk({req, " m2h_valid"}, m2h_valid, 1);
        chk({req, " m2h_data"}, m2h_data, rxq.pop_front());
        m2h_ready = 1'b1; tick(1);
        m2h_ready = 1'b0;
    endtask

    task automatic read_data(input int n, input string req);
        logic a;
        logic [7:0] b;
        i2c_start();
        wb({OWN, 1'b1}, a); chk({req, " read address ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            rb((i != n - 1), b);
            chk({req, " read byte"}, b, txq.pop_front());
        end
        i2c_stop();
    endtask

    task automatic write_data(input int n, input string req);
        logic a;
        byte unsigned v;
        i2c_start();
        wb({OWN, 1'b0}, a); chk({req, " write address ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            v = 8'($urandom);
            wb(v, a); chk({req, " data ack"}, a, 1);
            rxq.push_back(v);
        end
        i2c_stop();
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // watchdog: a hung run counts as one failed check
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic a;
        logic [7:0] b;
        int n;
        int unsigned seed;
        seed = $urandom(32'h1A2B3C);
        tick(10);
        rst_n = 1'b1;
        tick(2);

        // R11 reset state
        chk("R11 sda released", sda_oe, 0);
        chk("R11 m2h_valid low", m2h_valid, 0);
        chk("R11 h2m_ready high", h2m_ready, 1);

        // R8 foreign address ignored
        i2c_start();
        wb({7'h22, 1'b0}, a); chk("R8 foreign address nack", a, 0);
        i2c_stop();

        // R6 write without any grant is refused
        i2c_start();
        wb({OWN, 1'b0}, a); chk("R6 own address ack", a, 1);
        wb(8'h5C, a);       chk("R6 ungranted data nack", a, 0);
        i2c_stop();
        chk("R6 ungranted byte not stored", m2h_valid, 0);

        // R3 fill query: length byte then filler, nothing consumed
        n = 5 + int'($urandom % 10);
        for (int i = 0; i < n; i++) host_push(8'($urandom));
        query(8'hA4, "R1");
        i2c_start();
        wb({OWN, 1'b1}, a); chk("R3 read address ack", a, 1);
        rb(1'b1, b);        chk("R3 fill length", b, exp_fill());
        rb(1'b0, b);        chk("R3 trailing filler", b, 8'hFF);
        i2c_stop();
        read_data(n, "R5");
        i2c_start();
        wb({OWN, 1'b1}, a); chk("R5 read address ack", a, 1);
        rb(1'b0, b);        chk("R5 empty queue filler", b, 8'hFF);
        i2c_stop();

        // R2/R6 room query and granted writes, then room reflects them
        query(8'hA3, "R1");
        read_len(exp_room(), "R2");
        write_data(7, "R6");
        query(8'hA3, "R1");
        read_len(exp_room(), "R2 after writes");

        // R5 a room grant does not permit reads
        for (int i = 0; i < 3; i++) host_push(8'($urandom));
        i2c_start();
        wb({OWN, 1'b1}, a); chk("R5 read address ack", a, 1);
        rb(1'b0, b);        chk("R5 ungranted read filler", b, 8'hFF);
        i2c_stop();
        while (rxq.size() > 0) host_pop("R6");
        query(8'hA4, "R1");
        read_len(exp_fill(), "R3");
        read_data(3, "R5");

        // R4 unknown code: length 0 and no grant
        query(8'h5A, "R4");
        read_len(0, "R4");
        i2c_start();
        wb({OWN, 1'b0}, a); chk("R4 own address ack", a, 1);
        wb(8'h11, a);       chk("R4 write after unknown nack", a, 0);
        i2c_stop();
        chk("R4 nothing stored", m2h_valid, 0);

        // R7 overflow: fill to 62, the next byte is refused
        query(8'hA3, "R1");
        read_len(DEPTH, "R2");
        write_data(DEPTH, "R7 fill");
        i2c_start();
        wb({OWN, 1'b0}, a); chk("R7 own address ack", a, 1);
        wb(8'hC3, a);       chk("R7 overflow byte nack", a, 0);
        i2c_stop();
        query(8'hA3, "R1");
        read_len(0, "R7 full room");
        while (rxq.size() > 0) host_pop("R7");
        chk("R7 queue drained", m2h_valid, 0);

        // R9 read queue fill to 62, extra offer dropped
        for (int i = 0; i < DEPTH; i++) host_push(8'($urandom));
        chk("R9 h2m_ready low when full", h2m_ready, 0);
        h2m_data = 8'hEE; h2m_valid = 1'b1; tick(1); h2m_valid = 1'b0;
        query(8'hA4, "R1");
        read_len(DEPTH, "R3 full");
        read_data(DEPTH, "R9");
        chk("R9 h2m_ready high after drain", h2m_ready, 1);

        // random rounds of both directions
        for (int r = 0; r < 3; r++) begin
            n = 1 + int'($urandom % 12);
            for (int i = 0; i < n; i++) host_push(8'($urandom));
            query(8'hA4, "R1");
            read_len(exp_fill(), "R3 random");
            read_data(n, "R5 random");
            n = 1 + int'($urandom % 12);
            query(8'hA3, "R1");
            read_len(exp_room(), "R2 random");
            write_data(n, "R6 random");
            while (rxq.size() > 0) host_pop("R6 random");
        end
        chk("R10 sda released at end", sda_oe, 0);

        done = 1'b1;
        finish_run();
    end
endmodule